// File: doc/BRIEF.md
# ADC Result Limit and Offset Unit

This unit sits between an analog-to-digital converter and its result storage. Each raw sample arrives with a destination slot index. The unit checks the raw value against that slot's own high and low thresholds and records any violation in sticky status bits. A shared interrupt line reports those bits. It then subtracts the slot's offset and stores the corrected value in the slot's result register.

Software reaches the unit through a single-cycle register port. Reads are combinational and writes take effect on the clock edge. The address is `{group[2:0], index}`:

- Group 0: results (read-only).
- Group 1: high limits.
- Group 2: low limits.
- Group 3: offsets.
- Group 4: status. Index 0 holds the high flags and index 1 the low flags, with bit n belonging to slot n.

With eight slots the address is six bits wide.

Top module: `adc_limit_offset_unit`

## Requirements
- R1: After reset, every high limit reads 7FF8h, every low limit, offset and result reads 0000h, both status words read 0 and limit_irq_o is low.
- R2: Limit and offset registers keep only bits 14:3 of a write; bit 15 and bits 2:0 always read zero.
- R3: One cycle after a sample strobe, the result of the addressed slot reads (raw - offset) as a 16-bit two's-complement value with bits 2:0 zero; other slots keep their results, and writes to the result group have no effect.
- R4: A sample whose raw value is strictly greater than its slot's high limit sets status bit n at address 20h on the edge after the strobe; an equal value does not.
- R5: A sample whose raw value is strictly less than its slot's low limit sets status bit n at address 21h; an equal value does not.
- R6: Both limit checks use the raw sample, never the offset-corrected value.
- R7: A slot with the reset limits 7FF8h/0000h never raises a flag, whatever the sample.
- R8: Status bits are sticky; writing 1 to bit n of address 20h or 21h clears it, and writing 0 leaves it unchanged.
- R9: If a sample sets a flag in the same cycle that software clears it, the flag ends up set.
- R10: limit_irq_o is high exactly when any status bit is set.
- R11: Bits 15 and 2:0 of the sample input are ignored, so the raw value is sample bits 14:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_valid_i | input | 1 | One-cycle strobe for a new sample |
| sample_slot_i | input | 3 | Destination result slot |
| sample_data_i | input | 16 | Raw conversion value, data in bits 14:3 |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 6 | Register address {group, index} |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational |
| limit_irq_o | output | 1 | OR of all sticky limit flags |

## Verification
The hardest case to reach is a collision on the same edge: a sample that violates a limit arrives while software writes 1 to clear that slot's flag. The bench drives the strobe and the status write in the same cycle, then reads the flag back.

A second delicate case is a slot whose raw value and corrected value fall on opposite sides of a threshold. The bench sets a nonzero offset and chooses the raw value so that only the raw comparison trips the high limit, while only the corrected value would trip the low limit.

// File: rtl/adc_lim_pkg.sv
package adc_lim_pkg;
  localparam int DW = 16;
  localparam int NSLOT = 8;
  localparam int GRP_W = 3;
  localparam logic [DW-1:0] FIELD_MASK = 16'h7FF8;
  localparam logic [DW-1:0] HI_RST = 16'h7FF8;
  localparam logic [DW-1:0] LO_RST = 16'h0000;

  typedef enum logic [GRP_W-1:0] {
    GRP_RES = 3'd0,
    GRP_HI  = 3'd1,
    GRP_LO  = 3'd2,
    GRP_OFS = 3'd3,
    GRP_STS = 3'd4
  } grp_e;

  typedef struct packed {
    logic [DW-1:0] hi;
    logic [DW-1:0] lo;
    logic [DW-1:0] ofs;
  } slot_cfg_t;
endpackage

// File: rtl/adc_lim_cfg_regs.sv
module adc_lim_cfg_regs
  import adc_lim_pkg::*;
#(
  parameter int NUM_SLOTS = NSLOT,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  grp_e                            wr_grp_i,
  input  logic [SLOT_W-1:0]               wr_idx_i,
  input  logic [DW-1:0]                   wr_data_i,
  output slot_cfg_t [NUM_SLOTS-1:0]       cfg_o
);
  slot_cfg_t [NUM_SLOTS-1:0] cfg_q;
  logic [DW-1:0] wr_field;

  assign wr_field = wr_data_i & FIELD_MASK;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == SLOT_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[g].hi  <= HI_RST;
        cfg_q[g].lo  <= LO_RST;
        cfg_q[g].ofs <= '0;
      end else if (sel) begin
        unique case (wr_grp_i)
          GRP_HI:  cfg_q[g].hi  <= wr_field;
          GRP_LO:  cfg_q[g].lo  <= wr_field;
          GRP_OFS: cfg_q[g].ofs <= wr_field;
          default: ;
        endcase
      end
    end
  end

  assign cfg_o = cfg_q;

  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_q));
endmodule

// File: rtl/adc_lim_datapath.sv
module adc_lim_datapath
  import adc_lim_pkg::*;
(
  input  logic [DW-1:0] sample_i,
  input  slot_cfg_t     cfg_i,
  output logic [DW-1:0] raw_o,
  output logic [DW-1:0] corrected_o,
  output logic          hi_hit_o,
  output logic          lo_hit_o
);
  logic [DW-1:0] diff;

  always_comb begin
    raw_o       = sample_i & FIELD_MASK;
    diff        = raw_o - cfg_i.ofs;
    corrected_o = {diff[DW-1:3], 3'b000};
    hi_hit_o    = raw_o > cfg_i.hi;
    lo_hit_o    = raw_o < cfg_i.lo;
  end
endmodule

// File: rtl/adc_lim_status.sv
module adc_lim_status
  import adc_lim_pkg::*;
#(
  parameter int NUM_SLOTS = NSLOT,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic                 hi_hit_i,
  input  logic                 lo_hit_i,
  input  logic                 clr_hi_i,
  input  logic                 clr_lo_i,
  input  logic [NUM_SLOTS-1:0] clr_mask_i,
  output logic [NUM_SLOTS-1:0] hi_flags_o,
  output logic [NUM_SLOTS-1:0] lo_flags_o,
  output logic                 irq_o
);
  logic [NUM_SLOTS-1:0] hi_q, lo_q, slot_dec, hi_set, lo_set, hi_clr, lo_clr;

  always_comb begin
    slot_dec = '0;
    slot_dec[slot_i] = 1'b1;
    hi_set = (valid_i && hi_hit_i) ? slot_dec : '0;
    lo_set = (valid_i && lo_hit_i) ? slot_dec : '0;
    hi_clr = clr_hi_i ? clr_mask_i : '0;
    lo_clr = clr_lo_i ? clr_mask_i : '0;
  end

  // set takes priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= (hi_q & ~hi_clr) | hi_set;
      lo_q <= (lo_q & ~lo_clr) | lo_set;
    end
  end

  assign hi_flags_o = hi_q;
  assign lo_flags_o = lo_q;
  assign irq_o      = |{hi_q, lo_q};

  // R8
  hi_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_hi_i |=> ((hi_q & $past(hi_q)) == $past(hi_q)));

  // R8
  lo_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_lo_i |=> ((lo_q & $past(lo_q)) == $past(lo_q)));

  // R4
  hi_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && hi_hit_i) |=> hi_q[$past(slot_i)]);

  // R5
  lo_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lo_hit_i) |=> lo_q[$past(slot_i)]);
endmodule

// File: rtl/adc_limit_offset_unit.sv
module adc_limit_offset_unit
  import adc_lim_pkg::*;
#(
  parameter int NUM_SLOTS = NSLOT,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int ADDR_W = GRP_W + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [SLOT_W-1:0] sample_slot_i,
  input  logic [DW-1:0]     sample_data_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              limit_irq_o
);
  grp_e                      addr_grp;
  logic [SLOT_W-1:0]         addr_idx;
  slot_cfg_t [NUM_SLOTS-1:0] cfg;
  slot_cfg_t                 cfg_sel;
  logic [NUM_SLOTS-1:0][DW-1:0] result_q;
  logic [DW-1:0]             raw, corrected;
  logic                      hi_hit, lo_hit;
  logic [NUM_SLOTS-1:0]      hi_flags, lo_flags;
  logic                      clr_hi, clr_lo, sts_wr;

  assign addr_grp = grp_e'(reg_addr_i[ADDR_W-1 -: GRP_W]);
  assign addr_idx = reg_addr_i[SLOT_W-1:0];
  assign sts_wr   = reg_we_i && (addr_grp == GRP_STS);
  assign clr_hi   = sts_wr && (addr_idx == SLOT_W'(0));
  assign clr_lo   = sts_wr && (addr_idx == SLOT_W'(1));

  adc_lim_cfg_regs #(.NUM_SLOTS(NUM_SLOTS)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (reg_we_i),
    .wr_grp_i  (addr_grp),
    .wr_idx_i  (addr_idx),
    .wr_data_i (reg_wdata_i),
    .cfg_o     (cfg)
  );

  assign cfg_sel = cfg[sample_slot_i];

  adc_lim_datapath u_dp (
    .sample_i    (sample_data_i),
    .cfg_i       (cfg_sel),
    .raw_o       (raw),
    .corrected_o (corrected),
    .hi_hit_o    (hi_hit),
    .lo_hit_o    (lo_hit)
  );

  adc_lim_status #(.NUM_SLOTS(NUM_SLOTS)) u_sts (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (sample_valid_i),
    .slot_i     (sample_slot_i),
    .hi_hit_i   (hi_hit),
    .lo_hit_i   (lo_hit),
    .clr_hi_i   (clr_hi),
    .clr_lo_i   (clr_lo),
    .clr_mask_i (reg_wdata_i[NUM_SLOTS-1:0]),
    .hi_flags_o (hi_flags),
    .lo_flags_o (lo_flags),
    .irq_o      (limit_irq_o)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_res
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) result_q[g] <= '0;
      else if (sample_valid_i && (sample_slot_i == SLOT_W'(g))) result_q[g] <= corrected;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr_grp)
      GRP_RES: reg_rdata_o = result_q[addr_idx];
      GRP_HI:  reg_rdata_o = cfg[addr_idx].hi;
      GRP_LO:  reg_rdata_o = cfg[addr_idx].lo;
      GRP_OFS: reg_rdata_o = cfg[addr_idx].ofs;
      GRP_STS: begin
        if (addr_idx == SLOT_W'(0)) reg_rdata_o = DW'(hi_flags);
        else if (addr_idx == SLOT_W'(1)) reg_rdata_o = DW'(lo_flags);
      end
      default: reg_rdata_o = '0;
    endcase
  end

  // R3
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> $stable(result_q));

  // R7
  disabled_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && cfg_sel.hi == HI_RST && cfg_sel.lo == LO_RST)
    |=> (({hi_flags, lo_flags} | $past({hi_flags, lo_flags})) == $past({hi_flags, lo_flags})));

  // R11
  raw_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |-> ((raw & ~FIELD_MASK) == '0));
endmodule

// File: tb/tb_adc_limit_offset_unit.sv
module tb_adc_limit_offset_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_valid_i = 1'b0;
  logic [2:0]  sample_slot_i = '0;
  logic [15:0] sample_data_i = '0;
  logic        reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        limit_irq_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  adc_limit_offset_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sample_valid_i(sample_valid_i), .sample_slot_i(sample_slot_i),
    .sample_data_i(sample_data_i), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .limit_irq_o(limit_irq_o)
  );

  localparam logic [5:0] A_RES = 6'h00, A_HI = 6'h08, A_LO = 6'h10, A_OFS = 6'h18;
  localparam logic [5:0] A_STH = 6'h20, A_STL = 6'h21;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic bus_read(logic [5:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic push(logic [2:0] s, logic [15:0] v);
    @(negedge clk_i);
    sample_valid_i = 1'b1; sample_slot_i = s; sample_data_i = v;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int i = 0; i < 8; i++) begin
      bus_read(A_HI + 6'(i), d);  check("R1 hi", d, 16'h7FF8);
      bus_read(A_LO + 6'(i), d);  check("R1 lo", d, 16'h0000);
      bus_read(A_OFS + 6'(i), d); check("R1 ofs", d, 16'h0000);
      bus_read(A_RES + 6'(i), d); check("R1 res", d, 16'h0000);
    end
    bus_read(A_STH, d); check("R1 sth", d, 0);
    bus_read(A_STL, d); check("R1 stl", d, 0);
    check("R1 irq", 16'(limit_irq_o), 0);
  endtask

  task automatic t_fields();
    logic [15:0] d;
    bus_write(A_HI + 6'd2, 16'hFFFF);  bus_read(A_HI + 6'd2, d);  check("R2 hi mask", d, 16'h7FF8);
    bus_write(A_OFS + 6'd5, 16'h8007); bus_read(A_OFS + 6'd5, d); check("R2 ofs mask", d, 16'h0000);
    bus_write(A_LO + 6'd1, 16'h1234);  bus_read(A_LO + 6'd1, d);  check("R2 lo mask", d, 16'h1230);
    bus_write(A_HI + 6'd2, 16'h7FF8);
    bus_write(A_LO + 6'd1, 16'h0000);
  endtask

  task automatic t_disabled();
    logic [15:0] d;
    push(3'd0, 16'h7FF8);
    push(3'd0, 16'h0000);
    push(3'd0, 16'hFFFF);
    bus_read(A_STH, d); check("R7 no hi flag", d, 0);
    bus_read(A_STL, d); check("R7 no lo flag", d, 0);
    check("R7 irq low", 16'(limit_irq_o), 0);
  endtask

  task automatic t_sample_mask();
    logic [15:0] d;
    push(3'd0, 16'h8007); bus_read(A_RES, d); check("R11 low/high bits ignored", d, 16'h0000);
    push(3'd0, 16'hFFFF); bus_read(A_RES, d); check("R11 full scale", d, 16'h7FF8);
  endtask

  task automatic t_offset();
    logic [15:0] d;
    bus_write(A_OFS + 6'd3, 16'h0100);
    push(3'd3, 16'h0500); bus_read(A_RES + 6'd3, d); check("R3 corrected", d, 16'h0400);
    push(3'd3, 16'h0080); bus_read(A_RES + 6'd3, d); check("R3 negative", d, 16'hFF80);
    bus_read(A_RES, d); check("R3 other slot kept", d, 16'h7FF8);
    bus_write(A_RES + 6'd3, 16'h1111);
    bus_read(A_RES + 6'd3, d); check("R3 result read-only", d, 16'hFF80);
  endtask

  task automatic t_high();
    logic [15:0] d;
    bus_write(A_HI + 6'd4, 16'h4000);
    push(3'd4, 16'h4000); bus_read(A_STH, d); check("R4 equal no flag", d, 0);
    push(3'd4, 16'h4008); bus_read(A_STH, d); check("R4 above sets", d, 16'h0010);
    check("R10 irq on hi", 16'(limit_irq_o), 1);
  endtask

  task automatic t_low();
    logic [15:0] d;
    bus_write(A_LO + 6'd6, 16'h0200);
    push(3'd6, 16'h0200); bus_read(A_STL, d); check("R5 equal no flag", d, 0);
    push(3'd6, 16'h01F8); bus_read(A_STL, d); check("R5 below sets", d, 16'h0040);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    bus_write(A_STH, 16'h0000); bus_read(A_STH, d); check("R8 write 0 keeps", d, 16'h0010);
    bus_write(A_STH, 16'h0010); bus_read(A_STH, d); check("R8 w1c hi", d, 0);
    check("R10 irq from lo", 16'(limit_irq_o), 1);
    bus_write(A_STL, 16'h0040); bus_read(A_STL, d); check("R8 w1c lo", d, 0);
    check("R10 irq cleared", 16'(limit_irq_o), 0);
  endtask

  task automatic t_raw();
    logic [15:0] d;
    bus_write(A_HI + 6'd7, 16'h1000);
    bus_write(A_LO + 6'd7, 16'h0800);
    bus_write(A_OFS + 6'd7, 16'h0800);
    push(3'd7, 16'h1008);
    bus_read(A_STH, d); check("R6 raw above hi", d, 16'h0080);
    bus_read(A_RES + 6'd7, d); check("R6 result corrected", d, 16'h0808);
    bus_write(A_STH, 16'h0080);
    push(3'd7, 16'h0808);
    bus_read(A_STL, d); check("R6 corrected below lo ignored", d, 0);
    bus_read(A_STH, d); check("R6 no hi", d, 0);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    @(negedge clk_i);
    sample_valid_i = 1'b1; sample_slot_i = 3'd4; sample_data_i = 16'h5000;
    reg_we_i = 1'b1; reg_addr_i = A_STH; reg_wdata_i = 16'h0010;
    @(negedge clk_i);
    sample_valid_i = 1'b0; reg_we_i = 1'b0;
    bus_read(A_STH, d); check("R9 set beats clear", d, 16'h0010);
    check("R10 irq after collide", 16'(limit_irq_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_fields();
    t_disabled();
    t_sample_mask();
    t_offset();
    t_high();
    t_low();
    t_w1c();
    t_raw();
    t_collide();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule